// File: doc/BRIEF.md
# Early Branch Redirect

This block sits inside a pipeline stage and looks at each group of items before the group moves on to later stages. Each item already carries its decoded flags, its sequence number, its thread, a computed target and the target the predictor expected. The block checks only direct unconditional transfers. When the two targets of such a transfer differ, the block sends a redirect toward the fetch side for that thread. The redirect carries the item's sequence number and the corrected next address. In the same cycle, the block marks every newer item of that thread in the group as squashed.

The faulting item still goes forward, with its predicted target replaced by the computed one. Each thread has a small status machine that tracks run, blocked, unblocking and squashing. A redirect moves the thread to squashing. If the thread was held when the redirect arrived, the block also raises a one-cycle unblock indication. All outputs are registered, so results appear one clock after the group is presented.

Top module: `early_redirect`

## Requirements
- R1: Slot i of `grp_in` occupies bits [i*SLOT_W +: SLOT_W]. Inside a slot, from the LSB up, the fields are: predicted target (ADDR_W bits), computed target (ADDR_W bits), then five flag bits {is_ctrl, direct, uncond, pred_taken, taken} with taken lowest, then the sequence number (SEQ_W bits), the thread id (TID_W bits), an input-squashed bit and a valid bit at the top. One cycle later, `fwd_valid[i]` is 1 exactly when the slot was valid, not squashed on input, and not killed by a redirect.
- R2: Only live items flagged both direct and unconditional are checked. `resolved_cnt` equals the number of checked items that are forwarded in that group.
- R3: When a checked item's computed target differs from its predicted target, the item's thread gets a redirect one cycle later. `redir_valid[t]` is 1, and all three bits of `redir_flags[t*3 +: 3]` are set (bit0 mispredict, bit1 prediction incorrect, bit2 squash). `redir_seq` holds the item's sequence number, `redir_next` holds its computed target and `redir_taken` holds its taken flag.
- R4: The faulting item is forwarded, and its `fwd_target` carries the computed target. An item with no target mismatch forwards its predicted target unchanged.
- R5: Every valid item of the faulting thread whose sequence number is newer than the faulting one is killed, in any slot of the group. A killed item is not forwarded and shows `fwd_squashed`. Items of other threads are not affected. `fwd_squashed` is also set for valid items that arrive already squashed.
- R6: A thread gets at most one redirect per group. It comes from its lowest-numbered mismatching slot. A later mismatch of the same thread is killed and raises nothing.
- R7: "Newer" means that the SEQ_W-bit difference (a - b) is non-zero and has a clear top bit. This makes 16'h0001 newer than 16'hFFFE.
- R8: `fatal_err` is 1 one cycle after a group in which a forwarded item was predicted taken but is not a control transfer.
- R9: `thr_state` per thread uses 2 bits: RUN=0, BLOCKED=1, UNBLOCKING=2, SQUASHING=3. A redirect sets the thread to SQUASHING, and this takes priority over a stall. From SQUASHING, the thread returns to RUN on the next cycle if there is no stall and no new redirect.
- R10: `unblock_out[t]` pulses together with a redirect that finds the thread BLOCKED or UNBLOCKING. It stays 0 for a redirect that finds the thread in RUN.
- R11: With no redirect, a stall moves the thread to BLOCKED. When the stall drops, BLOCKED moves to UNBLOCKING. UNBLOCKING returns to RUN only once `skid_empty_in[t]` is 1.
- R12: While `rst_n` is low at a clock edge, all outputs become 0 and every thread returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_in | input | SLOTS*SLOT_W | Incoming group of items, packed per R1 |
| stall_in | input | THREADS | Per-thread stall request from later stages |
| skid_empty_in | input | THREADS | Per-thread indication that held items have drained |
| fwd_valid | output | SLOTS | Per-slot forward valid |
| fwd_squashed | output | SLOTS | Per-slot squashed marking |
| fwd_target | output | SLOTS*ADDR_W | Per-slot outgoing predicted target |
| resolved_cnt | output | $clog2(SLOTS+1) | Checked transfers forwarded in the group |
| fatal_err | output | 1 | Taken prediction on a non-control item |
| redir_valid | output | THREADS | Per-thread redirect |
| redir_flags | output | 3*THREADS | Mispredict, prediction-incorrect and squash flags |
| redir_seq | output | THREADS*SEQ_W | Sequence number of the faulting item |
| redir_next | output | THREADS*ADDR_W | Corrected next address |
| redir_taken | output | THREADS | Taken flag of the faulting item |
| unblock_out | output | THREADS | Unblock pulse raised with a redirect on a held thread |
| thr_state | output | 2*THREADS | Per-thread status code |

## Verification
The assertions assume that each thread's items appear in the group in ascending sequence order, so a thread's first mismatch in slot order is also its oldest. They also assume that no thread id is at or above THREADS. Every stimulus group in the bench lists a thread's items oldest first. The one exception is a deliberate case where an older fault sits behind a newer item, and that case still respects the assumption for mismatching items. All thread ids used are 0 or 1. Stall and skid-drained inputs change only between clock edges, and the status checks read the outputs one cycle later.

// File: rtl/er_pkg.sv
// Package: shared status codes and flag bit positions for the early redirect block.
// Assumes nothing beyond the parameters of the instantiating modules.
package er_pkg;
    typedef enum logic [1:0] {
        TS_RUN     = 2'd0,
        TS_BLOCKED = 2'd1,
        TS_UNBLK   = 2'd2,
        TS_SQUASH  = 2'd3
    } thr_state_t;

    // Flag bit offsets, counted up from the end of the two target fields.
    localparam int FL_TAKEN  = 0;
    localparam int FL_PTAKEN = 1;
    localparam int FL_UNCOND = 2;
    localparam int FL_DIRECT = 3;
    localparam int FL_CTRL   = 4;
    localparam int FL_COUNT  = 5;
endpackage

// File: rtl/er_slot_eval.sv
// Module: unpacks one slot and flags whether it is checked, whether its targets
// disagree, and whether it carries an illegal taken prediction.
// Assumes the slot layout documented for the top-level group input.
module er_slot_eval #(
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TID_W  = 1,
    localparam int SLOT_W = 2*ADDR_W + er_pkg::FL_COUNT + SEQ_W + TID_W + 2
) (
    input  logic [SLOT_W-1:0] slot_i,
    output logic              valid_o,
    output logic              sq_in_o,
    output logic              live_o,
    output logic [TID_W-1:0]  tid_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic              checked_o,
    output logic              mismatch_o,
    output logic              bad_pred_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] calc_o,
    output logic [ADDR_W-1:0] pred_o
);
    import er_pkg::*;

    localparam int FL_LO  = 2*ADDR_W;
    localparam int SEQ_LO = FL_LO + FL_COUNT;
    localparam int TID_LO = SEQ_LO + SEQ_W;
    localparam int SQ_BIT = TID_LO + TID_W;
    localparam int V_BIT  = SQ_BIT + 1;

    logic [FL_COUNT-1:0] fl;

    // Purpose: split the slot into fields and derive the per-slot check results.
    always_comb begin
        fl         = slot_i[FL_LO +: FL_COUNT];
        valid_o    = slot_i[V_BIT];
        sq_in_o    = slot_i[SQ_BIT];
        tid_o      = slot_i[TID_LO +: TID_W];
        seq_o      = slot_i[SEQ_LO +: SEQ_W];
        pred_o     = slot_i[0 +: ADDR_W];
        calc_o     = slot_i[ADDR_W +: ADDR_W];
        taken_o    = fl[FL_TAKEN];
        live_o     = valid_o && !sq_in_o;
        checked_o  = live_o && fl[FL_DIRECT] && fl[FL_UNCOND];
        mismatch_o = checked_o && (calc_o != pred_o);
        bad_pred_o = live_o && fl[FL_PTAKEN] && !fl[FL_CTRL];
    end
endmodule

// File: rtl/er_fault_select.sv
// Module: picks, per thread, the lowest-numbered mismatching slot. It then kills
// every live slot of that thread whose sequence number is newer (wrap-safe).
// Assumes thread ids below THREADS and per-thread ascending order in the group.
module er_fault_select #(
    parameter int SLOTS   = 4,
    parameter int THREADS = 2,
    parameter int SEQ_W   = 16,
    parameter int TID_W   = 1,
    localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]                 live_i,
    input  logic [SLOTS-1:0]                 mismatch_i,
    input  logic [SLOTS-1:0][TID_W-1:0]      tid_i,
    input  logic [SLOTS-1:0][SEQ_W-1:0]      seq_i,
    output logic [THREADS-1:0]               fault_v_o,
    output logic [THREADS-1:0][SIDX_W-1:0]   fault_slot_o,
    output logic [THREADS-1:0][SEQ_W-1:0]    fault_seq_o,
    output logic [SLOTS-1:0]                 kill_o
);
    // Wrap-safe age test: a is newer than b.
    function automatic logic is_newer(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    // Purpose: first mismatch in slot order for each thread.
    always_comb begin
        fault_v_o    = '0;
        fault_slot_o = '0;
        fault_seq_o  = '0;
        for (int t = 0; t < THREADS; t++) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (!fault_v_o[t] && mismatch_i[i] && (tid_i[i] == TID_W'(t))) begin
                    fault_v_o[t]    = 1'b1;
                    fault_slot_o[t] = SIDX_W'(i);
                    fault_seq_o[t]  = seq_i[i];
                end
            end
        end
    end

    // Purpose: mark newer live items of a faulting thread as killed.
    always_comb begin
        kill_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int t = 0; t < THREADS; t++) begin
                if (live_i[i] && (tid_i[i] == TID_W'(t)) && fault_v_o[t] &&
                    is_newer(seq_i[i], fault_seq_o[t])) begin
                    kill_o[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/er_thread_fsm.sv
// Module: per-thread status machine (run, blocked, unblocking, squashing) with a
// one-cycle unblock pulse when a redirect finds the thread held.
// Assumes stall and skid_empty are already synchronous to clk.
module er_thread_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               skid_empty_i,
    input  logic               redirect_i,
    output er_pkg::thr_state_t state_o,
    output logic               unblock_o
);
    import er_pkg::*;

    thr_state_t st_n;

    // Purpose: next status; redirect wins over stall, stall wins over release.
    always_comb begin
        st_n = state_o;
        if (redirect_i) begin
            st_n = TS_SQUASH;
        end else if (stall_i) begin
            st_n = TS_BLOCKED;
        end else begin
            case (state_o)
                TS_BLOCKED: st_n = TS_UNBLK;
                TS_UNBLK:   st_n = skid_empty_i ? TS_RUN : TS_UNBLK;
                TS_SQUASH:  st_n = TS_RUN;
                default:    st_n = TS_RUN;
            endcase
        end
    end

    // Purpose: status register and unblock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o   <= TS_RUN;
            unblock_o <= 1'b0;
        end else begin
            state_o   <= st_n;
            unblock_o <= redirect_i && ((state_o == TS_BLOCKED) || (state_o == TS_UNBLK));
        end
    end

    a_r11_blocked_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == TS_BLOCKED && !stall_i && !redirect_i) |=> (state_o == TS_UNBLK));

    a_r9_squash_returns_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == TS_SQUASH && !stall_i && !redirect_i) |=> (state_o == TS_RUN));

    a_r11_unblock_holds_until_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == TS_UNBLK && !stall_i && !redirect_i && !skid_empty_i) |=> (state_o == TS_UNBLK));
endmodule

// File: rtl/early_redirect.sv
// Module: early check of direct unconditional transfers in a group. It registers
// the forwarded group, the per-thread redirects and the per-thread status.
// Assumes per-thread ascending sequence order in slot order and valid thread ids.
module early_redirect #(
    parameter int SLOTS   = 4,
    parameter int THREADS = 2,
    parameter int SEQ_W   = 16,
    parameter int ADDR_W  = 32,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int SLOT_W = 2*ADDR_W + er_pkg::FL_COUNT + SEQ_W + TID_W + 2,
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS*SLOT_W-1:0]   grp_in,
    input  logic [THREADS-1:0]        stall_in,
    input  logic [THREADS-1:0]        skid_empty_in,
    output logic [SLOTS-1:0]          fwd_valid,
    output logic [SLOTS-1:0]          fwd_squashed,
    output logic [SLOTS*ADDR_W-1:0]   fwd_target,
    output logic [CNT_W-1:0]          resolved_cnt,
    output logic                      fatal_err,
    output logic [THREADS-1:0]        redir_valid,
    output logic [3*THREADS-1:0]      redir_flags,
    output logic [THREADS*SEQ_W-1:0]  redir_seq,
    output logic [THREADS*ADDR_W-1:0] redir_next,
    output logic [THREADS-1:0]        redir_taken,
    output logic [THREADS-1:0]        unblock_out,
    output logic [2*THREADS-1:0]      thr_state
);
    import er_pkg::*;

    localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0]               s_valid, s_sq, s_live, s_chk, s_mm, s_bad, s_taken;
    logic [SLOTS-1:0][TID_W-1:0]    s_tid;
    logic [SLOTS-1:0][SEQ_W-1:0]    s_seq;
    logic [SLOTS-1:0][ADDR_W-1:0]   s_calc, s_pred;
    logic [THREADS-1:0]             f_v;
    logic [THREADS-1:0][SIDX_W-1:0] f_slot;
    logic [THREADS-1:0][SEQ_W-1:0]  f_seq;
    logic [SLOTS-1:0]               kill;
    logic [SLOTS-1:0]               fwd_n;
    logic [CNT_W-1:0]               cnt_n;
    logic [THREADS-1:0][SIDX_W-1:0] redir_slot_q;

    // Per-slot field decode and target compare.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        er_slot_eval #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TID_W(TID_W)) u_eval (
            .slot_i     (grp_in[i*SLOT_W +: SLOT_W]),
            .valid_o    (s_valid[i]),
            .sq_in_o    (s_sq[i]),
            .live_o     (s_live[i]),
            .tid_o      (s_tid[i]),
            .seq_o      (s_seq[i]),
            .checked_o  (s_chk[i]),
            .mismatch_o (s_mm[i]),
            .bad_pred_o (s_bad[i]),
            .taken_o    (s_taken[i]),
            .calc_o     (s_calc[i]),
            .pred_o     (s_pred[i])
        );
    end

    er_fault_select #(.SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_sel (
        .live_i       (s_live),
        .mismatch_i   (s_mm),
        .tid_i        (s_tid),
        .seq_i        (s_seq),
        .fault_v_o    (f_v),
        .fault_slot_o (f_slot),
        .fault_seq_o  (f_seq),
        .kill_o       (kill)
    );

    // Purpose: forward mask and count of forwarded checked transfers.
    always_comb begin
        fwd_n = s_live & ~kill;
        cnt_n = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cnt_n = cnt_n + CNT_W'(s_chk[i] && fwd_n[i]);
        end
    end

    // Purpose: register the outgoing group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid    <= '0;
            fwd_squashed <= '0;
            fwd_target   <= '0;
            resolved_cnt <= '0;
            fatal_err    <= 1'b0;
        end else begin
            fwd_valid    <= fwd_n;
            fwd_squashed <= s_valid & (s_sq | kill);
            for (int i = 0; i < SLOTS; i++) begin
                fwd_target[i*ADDR_W +: ADDR_W] <= s_mm[i] ? s_calc[i] : s_pred[i];
            end
            resolved_cnt <= cnt_n;
            fatal_err    <= |(s_bad & fwd_n);
        end
    end

    // Purpose: register the per-thread redirect bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid  <= '0;
            redir_flags  <= '0;
            redir_seq    <= '0;
            redir_next   <= '0;
            redir_taken  <= '0;
            redir_slot_q <= '0;
        end else begin
            for (int t = 0; t < THREADS; t++) begin
                redir_valid[t]                    <= f_v[t];
                redir_flags[t*3 +: 3]             <= {3{f_v[t]}};
                redir_seq[t*SEQ_W +: SEQ_W]       <= f_v[t] ? f_seq[t] : '0;
                redir_next[t*ADDR_W +: ADDR_W]    <= f_v[t] ? s_calc[f_slot[t]] : '0;
                redir_taken[t]                    <= f_v[t] && s_taken[f_slot[t]];
                redir_slot_q[t]                   <= f_slot[t];
            end
        end
    end

    // Per-thread status machines and redirect-side checks.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        thr_state_t st;
        er_thread_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .stall_i      (stall_in[t]),
            .skid_empty_i (skid_empty_in[t]),
            .redirect_i   (f_v[t]),
            .state_o      (st),
            .unblock_o    (unblock_out[t])
        );
        assign thr_state[t*2 +: 2] = st;

        a_r9_squash_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
            redir_valid[t] |-> (thr_state[t*2 +: 2] == TS_SQUASH));

        a_r10_unblock_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n)
            unblock_out[t] |-> redir_valid[t]);

        a_r4_fault_item_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
            redir_valid[t] |-> (fwd_valid[redir_slot_q[t]] &&
                (fwd_target[redir_slot_q[t]*ADDR_W +: ADDR_W] == redir_next[t*ADDR_W +: ADDR_W])));
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_chk
        a_r5_killed_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
            !(fwd_valid[i] && fwd_squashed[i]));
    end

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        resolved_cnt <= CNT_W'($countones(fwd_valid)));
endmodule

// File: tb/early_redirect_bench.sv
module early_redirect_bench;
    localparam int SLOTS = 4, THREADS = 2, SEQ_W = 16, ADDR_W = 32;
    localparam int TID_W = 1;
    localparam int SLOT_W = 2*ADDR_W + 5 + SEQ_W + TID_W + 2;

    typedef struct packed {
        logic       v;
        logic       sq;
        logic       tid;
        logic [15:0] seq;
        logic [4:0] fl;     // {ctrl, direct, uncond, pred_taken, taken}
        logic [7:0] calc;
        logic [7:0] pred;
    } bslot_t;

    typedef struct packed {
        bslot_t     s0, s1, s2, s3;
        logic [3:0] ev;
        logic [3:0] esq;
        logic [1:0] erv;
        logic [15:0] eseq0;
        logic [7:0] enext0;
        logic [15:0] eseq1;
        logic [7:0] enext1;
        logic [2:0] ecnt;
        logic       efat;
    } vec_t;

    localparam logic [4:0] P = 5'b00000;
    localparam logic [4:0] J = 5'b11111;
    localparam logic [4:0] B = 5'b00010;
    localparam logic [4:0] C = 5'b11011;
    localparam bslot_t NOS = '0;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        // 0: plain run, everything forwarded (R1)
        '{'{1'b1,1'b0,1'b0,16'd10,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd11,P,8'h00,8'h00},
          '{1'b1,1'b0,1'b0,16'd12,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd13,P,8'h00,8'h00},
          4'b1111,4'b0000,2'b00,16'd0,8'h00,16'd0,8'h00,3'd0,1'b0},
        // 1: matching jump counted, no redirect (R2)
        '{'{1'b1,1'b0,1'b0,16'd20,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd21,J,8'h40,8'h40},
          '{1'b1,1'b0,1'b0,16'd22,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd23,P,8'h00,8'h00},
          4'b1111,4'b0000,2'b00,16'd0,8'h00,16'd0,8'h00,3'd1,1'b0},
        // 2: mismatch in slot 1 kills slots 2,3 (R3, R5)
        '{'{1'b1,1'b0,1'b0,16'd30,P,8'h99,8'h33}, '{1'b1,1'b0,1'b0,16'd31,J,8'h50,8'h44},
          '{1'b1,1'b0,1'b0,16'd32,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd33,P,8'h00,8'h00},
          4'b0011,4'b1100,2'b01,16'd31,8'h50,16'd0,8'h00,3'd1,1'b0},
        // 3: both threads fault; other thread untouched (R5)
        '{'{1'b1,1'b0,1'b0,16'd40,J,8'h60,8'h10}, '{1'b1,1'b0,1'b1,16'd100,P,8'h00,8'h00},
          '{1'b1,1'b0,1'b0,16'd41,P,8'h00,8'h00}, '{1'b1,1'b0,1'b1,16'd101,J,8'h70,8'h71},
          4'b1011,4'b0100,2'b11,16'd40,8'h60,16'd101,8'h70,3'd2,1'b0},
        // 4: R6 oldest fault wins; conditional transfer not checked (R2)
        '{'{1'b1,1'b0,1'b1,16'd200,J,8'h11,8'h12}, '{1'b1,1'b0,1'b1,16'd201,J,8'h22,8'h23},
          '{1'b1,1'b0,1'b0,16'd50,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd51,C,8'h20,8'h21},
          4'b1101,4'b0010,2'b10,16'd0,8'h00,16'd200,8'h11,3'd1,1'b0},
        // 5: R7 sequence wrap
        '{'{1'b1,1'b0,1'b0,16'hFFFE,J,8'h30,8'h31}, '{1'b1,1'b0,1'b0,16'hFFFF,P,8'h00,8'h00},
          '{1'b1,1'b0,1'b0,16'h0001,P,8'h00,8'h00}, '{1'b1,1'b0,1'b1,16'h0005,P,8'h00,8'h00},
          4'b1001,4'b0110,2'b01,16'hFFFE,8'h30,16'd0,8'h00,3'd1,1'b0},
        // 6: R8 taken prediction on a non-control item
        '{'{1'b1,1'b0,1'b0,16'd60,B,8'h00,8'h00}, NOS, NOS, NOS,
          4'b0001,4'b0000,2'b00,16'd0,8'h00,16'd0,8'h00,3'd0,1'b1},
        // 7: squashed-on-input mismatch ignored, invalid slot ignored (R1, R5)
        '{'{1'b1,1'b1,1'b0,16'd70,J,8'h05,8'h06}, '{1'b0,1'b0,1'b0,16'd71,J,8'h07,8'h08}, NOS, NOS,
          4'b0000,4'b0001,2'b00,16'd0,8'h00,16'd0,8'h00,3'd0,1'b0},
        // 8: newer item in an earlier slot is killed by seq compare (R5)
        '{'{1'b1,1'b0,1'b0,16'd81,P,8'h00,8'h00}, '{1'b1,1'b0,1'b0,16'd80,J,8'h90,8'h91}, NOS, NOS,
          4'b0010,4'b0001,2'b01,16'd80,8'h90,16'd0,8'h00,3'd1,1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SLOTS*SLOT_W-1:0]   grp_in = '0;
    logic [THREADS-1:0]        stall_in = '0;
    logic [THREADS-1:0]        skid_empty_in = '1;
    logic [SLOTS-1:0]          fwd_valid, fwd_squashed;
    logic [SLOTS*ADDR_W-1:0]   fwd_target;
    logic [2:0]                resolved_cnt;
    logic                      fatal_err;
    logic [THREADS-1:0]        redir_valid, redir_taken, unblock_out;
    logic [3*THREADS-1:0]      redir_flags;
    logic [THREADS*SEQ_W-1:0]  redir_seq;
    logic [THREADS*ADDR_W-1:0] redir_next;
    logic [2*THREADS-1:0]      thr_state;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    early_redirect #(.SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_early_redirect (
        .clk(clk), .rst_n(rst_n), .grp_in(grp_in), .stall_in(stall_in),
        .skid_empty_in(skid_empty_in), .fwd_valid(fwd_valid), .fwd_squashed(fwd_squashed),
        .fwd_target(fwd_target), .resolved_cnt(resolved_cnt), .fatal_err(fatal_err),
        .redir_valid(redir_valid), .redir_flags(redir_flags), .redir_seq(redir_seq),
        .redir_next(redir_next), .redir_taken(redir_taken), .unblock_out(unblock_out),
        .thr_state(thr_state)
    );

    function automatic logic [SLOT_W-1:0] pack(bslot_t s);
        return {s.v, s.sq, s.tid, s.seq, s.fl, {(ADDR_W-8){1'b0}}, s.calc, {(ADDR_W-8){1'b0}}, s.pred};
    endfunction

    function automatic logic [SLOTS*SLOT_W-1:0] pack_grp(vec_t v);
        return {pack(v.s3), pack(v.s2), pack(v.s1), pack(v.s0)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 fwd_valid", 64'(fwd_valid), 0);
        chk("R12 redir_valid", 64'(redir_valid), 0);
        chk("R12 thr_state", 64'(thr_state), 0);
        chk("R12 fatal", 64'(fatal_err), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            grp_in = pack_grp(VT[k]);
            @(negedge clk);
            chk($sformatf("R1 v%0d fwd_valid", k), 64'(fwd_valid), 64'(VT[k].ev));
            chk($sformatf("R5 v%0d fwd_squashed", k), 64'(fwd_squashed), 64'(VT[k].esq));
            chk($sformatf("R3 R6 v%0d redir_valid", k), 64'(redir_valid), 64'(VT[k].erv));
            if (VT[k].erv[0]) begin
                chk($sformatf("R3 R7 v%0d seq t0", k), 64'(redir_seq[15:0]), 64'(VT[k].eseq0));
                chk($sformatf("R3 v%0d next t0", k), 64'(redir_next[31:0]), 64'(VT[k].enext0));
            end
            if (VT[k].erv[1]) begin
                chk($sformatf("R3 R6 v%0d seq t1", k), 64'(redir_seq[31:16]), 64'(VT[k].eseq1));
                chk($sformatf("R3 v%0d next t1", k), 64'(redir_next[63:32]), 64'(VT[k].enext1));
            end
            chk($sformatf("R2 v%0d resolved_cnt", k), 64'(resolved_cnt), 64'(VT[k].ecnt));
            chk($sformatf("R8 v%0d fatal", k), 64'(fatal_err), 64'(VT[k].efat));
        end

        // R4 target rewrite and R3 flags/taken
        grp_in = pack_grp(VT[2]);
        @(negedge clk);
        chk("R4 fault target", 64'(fwd_target[63:32]), 64'h50);
        chk("R4 plain target kept", 64'(fwd_target[31:0]), 64'h33);
        chk("R3 flags", 64'(redir_flags[2:0]), 64'b111);
        chk("R3 taken", 64'(redir_taken[0]), 1);
        chk("R9 squash on redirect", 64'(thr_state[1:0]), 3);
        grp_in = '0;
        @(negedge clk);
        chk("R9 squash returns to run", 64'(thr_state[1:0]), 0);

        // R11 stall sequence on thread 0
        stall_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 blocked", 64'(thr_state[1:0]), 1);
        stall_in[0] = 1'b0;
        skid_empty_in[0] = 1'b0;
        @(negedge clk);
        chk("R11 unblocking", 64'(thr_state[1:0]), 2);
        @(negedge clk);
        chk("R11 waits for drain", 64'(thr_state[1:0]), 2);
        skid_empty_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 back to run", 64'(thr_state[1:0]), 0);

        // R10 redirect on a blocked thread raises unblock, beats the stall (R9)
        stall_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 blocked again", 64'(thr_state[1:0]), 1);
        grp_in = {{(3*SLOT_W){1'b0}}, pack('{1'b1,1'b0,1'b0,16'h0100,J,8'h44,8'h45})};
        @(negedge clk);
        chk("R10 unblock pulse", 64'(unblock_out[0]), 1);
        chk("R9 redirect beats stall", 64'(thr_state[1:0]), 3);
        grp_in = '0;
        stall_in[0] = 1'b0;
        @(negedge clk);
        chk("R10 pulse is one cycle", 64'(unblock_out[0]), 0);
        chk("R9 run after squash", 64'(thr_state[1:0]), 0);

        // R10 redirect while running: no unblock
        grp_in = {{(3*SLOT_W){1'b0}}, pack('{1'b1,1'b0,1'b0,16'h0200,J,8'h44,8'h45})};
        @(negedge clk);
        chk("R10 no unblock from run", 64'(unblock_out[0]), 0);
        chk("R3 redirect from run", 64'(redir_valid[0]), 1);
        grp_in = '0;
        @(negedge clk);

        // R12 reset mid-run
        grp_in = pack_grp(VT[3]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset clears redirect", 64'(redir_valid), 0);
        chk("R12 reset clears state", 64'(thr_state), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule